// File: doc/BRIEF.md
# Coprocessor Escape Trap Checker

This block sits on the CPU side of a processor that works with an attached floating-point coprocessor. Each instruction slot presents the leading opcode byte along with some qualifiers. The qualifiers say whether the slot is a WAIT, whether this escape instruction must look for an error left behind by an earlier one, and the current level of the coprocessor's active-low error line. From these inputs and four mode flags, the block picks exactly one outcome for the slot:

- hand the instruction to the coprocessor,
- raise the device-not-available trap (exception 7), or
- report a pending coprocessor error.

The block owns the four mode flags:

| Flag | Meaning |
|------|---------|
| emulate | Escape instructions are emulated in software. |
| monitor | A coprocessor is really present. |
| switched | A task switch has happened since the coprocessor context was last saved. |
| wide | Which coprocessor protocol width to use. |

A control-register write loads all four flags. A task-switch event sets the switched flag. The wide flag also takes the inverse of the error line in the first cycle after reset is released, so the kind of coprocessor attached is detected at power-up.

The outcome is registered. It shows as a one-cycle pulse in the cycle after the instruction slot, and it is computed from the flag values held during that slot.

Top module: `cop_esc_gate`

## Requirements
- R1: An instruction slot with `opc_valid` high, `opc_is_wait` low and opcode bits [7:3] equal to 11011 (bytes 0xD8 to 0xDF) is an escape instruction; with emulate and switched both clear and no error reported, it raises `cop_fwd` in the next cycle.
- R2: A valid slot that is neither an escape opcode nor flagged WAIT, and any cycle with `opc_valid` low, leaves `cop_fwd`, `nm_trap` and `cop_err` all low in the next cycle.
- R3: An escape instruction with emulate set raises `nm_trap`, whatever the switched flag and the error line are.
- R4: An escape instruction with emulate clear and switched set raises `nm_trap`.
- R5: A slot with `opc_is_wait` high is treated as WAIT whatever the opcode is. It raises `nm_trap` only when monitor and switched are both set; otherwise it produces no outcome. The emulate flag has no effect on it.
- R6: A `task_switch` pulse sets the switched flag for the next slot. It wins over a control-register write in the same cycle that clears switched.
- R7: A control-register write (`cr0_we`) loads monitor from bit 1, emulate from bit 2, switched from bit 3 and wide from bit 4 of `cr0_wdata`. A slot presented in the same cycle as the write still uses the old flags.
- R8: In the first clock after `rst_n` rises, the wide flag takes the inverse of `cop_error_n` (line low means set). A control-register write in that same cycle wins over this sample.
- R9: `proto_wide` shows the wide flag: 1 selects the 32-bit coprocessor protocol and 0 selects the 16-bit protocol.
- R10: An escape instruction with emulate and switched both clear raises `cop_err`, and not `cop_fwd`, when `chk_err` is high and `cop_error_n` is low. In every other case it forwards.
- R11: Per cycle, at most one of `cop_fwd`, `nm_trap` and `cop_err` is high. Each is a single-cycle pulse for its own slot.
- R12: While `rst_n` is low, all outcome outputs are low and emulate, monitor, switched and wide are all clear (`proto_wide` is 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opc_valid | input | 1 | An instruction slot is presented this cycle |
| opc_byte | input | 8 | Leading opcode byte of the slot |
| opc_is_wait | input | 1 | Slot is a WAIT instruction |
| chk_err | input | 1 | This escape instruction checks for a pending coprocessor error |
| cop_error_n | input | 1 | Coprocessor error line, active low |
| task_switch | input | 1 | Task-switch event pulse |
| cr0_we | input | 1 | Control-register write strobe |
| cr0_wdata | input | 32 | Control-register write data |
| cop_fwd | output | 1 | Forward the instruction to the coprocessor |
| nm_trap | output | 1 | Raise the device-not-available trap |
| cop_err | output | 1 | Report a pending coprocessor error |
| proto_wide | output | 1 | 1 selects the 32-bit protocol, 0 the 16-bit protocol |

## Verification
The bench builds the block with its default parameters. These are an 8-bit opcode with a 5-bit escape prefix, a 32-bit control word with the flags at bits 1 to 4, and the registered-outcome variant.

With this setting, the one-cycle outcome latency lines up with the flag updates made in the same cycle. This makes the old-flags-for-this-slot rule and the write-versus-task-switch priority observable at the ports. Two resets, taken with the error line at each level, and a reset released together with a control-register write reach both sides of the power-up sample. The directed cases are followed by a long random phase that mixes escape, WAIT and other opcodes with flag writes and task switches.

// File: rtl/cop_esc_pkg.sv
package cop_esc_pkg;
   typedef struct packed {
      logic wide;
      logic switched;
      logic emulate;
      logic monitor;
   } cop_flags_t;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_FWD  = 2'd1,
      ACT_NM   = 2'd2,
      ACT_CERR = 2'd3
   } cop_act_e;
endpackage

// File: rtl/cop_esc_match.sv
module cop_esc_match #(
   parameter int OPC_W = 8,
   parameter int PFX_W = 5,
   parameter logic [PFX_W-1:0] PFX = 5'b11011
) (
   input  logic [OPC_W-1:0] opc,
   output logic             hit
);
   // Escape prefix sits in the most significant bits of the opcode byte.
   assign hit = (opc[OPC_W-1 -: PFX_W] == PFX);
endmodule

// File: rtl/cop_cr0_flags.sv
module cop_cr0_flags
   import cop_esc_pkg::*;
#(
   parameter int CR0_W   = 32,
   parameter int MON_POS = 1,
   parameter int EMU_POS = 2,
   parameter int SW_POS  = 3,
   parameter int WIDE_POS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_n,
   input  logic             task_sw,
   input  logic             wr_en,
   input  logic [CR0_W-1:0] wr_data,
   output cop_flags_t       flags
);
   logic boot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags  <= '0;
         boot_q <= 1'b1;
      end else begin
         boot_q <= 1'b0;
         if (wr_en) begin
            flags.monitor  <= wr_data[MON_POS];
            flags.emulate  <= wr_data[EMU_POS];
            flags.switched <= wr_data[SW_POS];
            flags.wide     <= wr_data[WIDE_POS];
         end else if (boot_q) begin
            // power-up detection: low error line means the wide part
            flags.wide <= ~err_n;
         end
         if (task_sw) flags.switched <= 1'b1;
      end
   end

   // R6
   task_sets_switched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      task_sw |=> flags.switched);
endmodule

// File: rtl/cop_trap_decide.sv
module cop_trap_decide
   import cop_esc_pkg::*;
(
   input  logic       valid,
   input  logic       is_wait,
   input  logic       esc_hit,
   input  logic       chk_err,
   input  logic       err_n,
   input  cop_flags_t flags,
   output cop_act_e   act
);
   always_comb begin
      act = ACT_NONE;
      if (valid) begin
         if (is_wait) begin
            if (flags.monitor && flags.switched) act = ACT_NM;
         end else if (esc_hit) begin
            if (flags.emulate)            act = ACT_NM;
            else if (flags.switched)      act = ACT_NM;
            else if (chk_err && !err_n)   act = ACT_CERR;
            else                          act = ACT_FWD;
         end
      end
   end
endmodule

// File: rtl/cop_esc_gate.sv
module cop_esc_gate
   import cop_esc_pkg::*;
#(
   parameter int OPC_W    = 8,
   parameter int PFX_W    = 5,
   parameter logic [PFX_W-1:0] ESC_PFX = 5'b11011,
   parameter int CR0_W    = 32,
   parameter int MON_POS  = 1,
   parameter int EMU_POS  = 2,
   parameter int SW_POS   = 3,
   parameter int WIDE_POS = 4,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             opc_valid,
   input  logic [OPC_W-1:0] opc_byte,
   input  logic             opc_is_wait,
   input  logic             chk_err,
   input  logic             cop_error_n,
   input  logic             task_switch,
   input  logic             cr0_we,
   input  logic [CR0_W-1:0] cr0_wdata,
   output logic             cop_fwd,
   output logic             nm_trap,
   output logic             cop_err,
   output logic             proto_wide
);
   localparam int MAX_POS = (MON_POS > EMU_POS ? MON_POS : EMU_POS) > (SW_POS > WIDE_POS ? SW_POS : WIDE_POS)
                            ? (MON_POS > EMU_POS ? MON_POS : EMU_POS) : (SW_POS > WIDE_POS ? SW_POS : WIDE_POS);

   if (PFX_W > OPC_W || PFX_W < 1) begin : g_bad_pfx
      $error("escape prefix width must be 1..OPC_W");
   end
   if (MAX_POS >= CR0_W) begin : g_bad_pos
      $error("flag bit position outside the control word");
   end

   cop_flags_t flags;
   logic       esc_hit;
   cop_act_e   act_d, act_q;

   cop_esc_match #(.OPC_W(OPC_W), .PFX_W(PFX_W), .PFX(ESC_PFX)) u_match (
      .opc (opc_byte),
      .hit (esc_hit)
   );

   cop_cr0_flags #(
      .CR0_W(CR0_W), .MON_POS(MON_POS), .EMU_POS(EMU_POS),
      .SW_POS(SW_POS), .WIDE_POS(WIDE_POS)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .err_n   (cop_error_n),
      .task_sw (task_switch),
      .wr_en   (cr0_we),
      .wr_data (cr0_wdata),
      .flags   (flags)
   );

   cop_trap_decide u_decide (
      .valid   (opc_valid),
      .is_wait (opc_is_wait),
      .esc_hit (esc_hit),
      .chk_err (chk_err),
      .err_n   (cop_error_n),
      .flags   (flags),
      .act     (act_d)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) act_q <= ACT_NONE;
         else        act_q <= act_d;
      end

      // R2
      other_opcode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!opc_valid || (!opc_is_wait && !esc_hit)) |=> (!cop_fwd && !nm_trap && !cop_err));
      // R3
      emulate_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (opc_valid && !opc_is_wait && esc_hit && flags.emulate) |=> nm_trap);
      // R5
      wait_unmonitored_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (opc_valid && opc_is_wait && !flags.monitor) |=> !nm_trap);
      // R10
      pending_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (opc_valid && !opc_is_wait && esc_hit && !flags.emulate && !flags.switched
          && chk_err && !cop_error_n) |=> (cop_err && !cop_fwd));
   end else begin : g_comb
      assign act_q = act_d;
   end

   assign cop_fwd    = (act_q == ACT_FWD);
   assign nm_trap    = (act_q == ACT_NM);
   assign cop_err    = (act_q == ACT_CERR);
   assign proto_wide = flags.wide;
endmodule

// File: tb/tb_cop_esc_gate.sv
`timescale 1ns/1ps
module tb_cop_esc_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iv = 1'b0, wt = 1'b0, chk = 1'b0, errn = 1'b1, tsw = 1'b0, we = 1'b0;
   logic [7:0]  opc = 8'h00;
   logic [31:0] wd = '0;
   logic        fwd, nm, cerr, wide;

   int vectors = 0, miscompares = 0;
   bit done = 0;
   string cur_req = "R12";

   // reference state
   bit m_mon = 0, m_emu = 0, m_sw = 0, m_wide = 0, m_boot = 1;
   bit e_f = 0, e_n = 0, e_c = 0;

   always #2.5 clk = ~clk;

   cop_esc_gate dut (
      .clk(clk), .rst_n(rst_n), .opc_valid(iv), .opc_byte(opc), .opc_is_wait(wt),
      .chk_err(chk), .cop_error_n(errn), .task_switch(tsw), .cr0_we(we),
      .cr0_wdata(wd), .cop_fwd(fwd), .nm_trap(nm), .cop_err(cerr), .proto_wide(wide)
   );

   task automatic cycle();
      @(posedge clk);
      if (!rst_n) begin
         e_f = 0; e_n = 0; e_c = 0;
         m_mon = 0; m_emu = 0; m_sw = 0; m_wide = 0; m_boot = 1;
      end else begin
         e_f = 0; e_n = 0; e_c = 0;
         if (iv) begin
            if (wt) e_n = m_mon && m_sw;
            else if (opc[7:3] == 5'b11011) begin
               if (m_emu || m_sw)      e_n = 1;
               else if (chk && !errn)  e_c = 1;
               else                    e_f = 1;
            end
         end
         if (we) begin
            m_mon = wd[1]; m_emu = wd[2]; m_sw = wd[3]; m_wide = wd[4];
         end else if (m_boot) m_wide = !errn;
         if (tsw) m_sw = 1;
         m_boot = 0;
      end
      @(negedge clk);
      vectors++;
      if (fwd !== e_f || nm !== e_n || cerr !== e_c || wide !== m_wide) begin
         miscompares++;
         $display("FAIL %s: fwd/nm/err/wide actual=%b%b%b%b expected=%b%b%b%b",
                  cur_req, fwd, nm, cerr, wide, e_f, e_n, e_c, m_wide);
      end
   endtask

   task automatic slot(input bit v, input bit w, input logic [7:0] o, input bit c, input bit en);
      iv = v; wt = w; opc = o; chk = c; errn = en; tsw = 0; we = 0;
      cycle();
   endtask

   task automatic wr_cr0(input logic [31:0] d, input bit t);
      iv = 0; wt = 0; we = 1; wd = d; tsw = t;
      cycle();
      we = 0; tsw = 0;
   endtask

   task automatic do_reset(input bit en, input bit wr_first, input logic [31:0] d);
      rst_n = 0; iv = 0; wt = 0; tsw = 0; we = 0; errn = en;
      cur_req = "R12";
      repeat (3) cycle();
      rst_n = 1;
      cur_req = "R8";
      we = wr_first; wd = d;
      cycle();
      we = 0;
   endtask

   initial begin
      // R12 reset, R8 power-up sample with error line low -> wide set
      do_reset(1'b0, 1'b0, '0);
      cur_req = "R9"; slot(0, 0, 8'h00, 0, 1);
      // R1 escape forwarded
      cur_req = "R1";
      slot(1, 0, 8'hD9, 0, 1); slot(1, 0, 8'hD8, 0, 1); slot(1, 0, 8'hDF, 0, 1);
      slot(0, 0, 8'h00, 0, 1);
      // R2 other opcodes silent
      cur_req = "R2";
      slot(1, 0, 8'hD7, 0, 1); slot(1, 0, 8'h9B, 0, 1); slot(1, 0, 8'hE0, 1, 0);
      slot(0, 0, 8'hDA, 0, 1);
      // R10 pending error
      cur_req = "R10";
      slot(1, 0, 8'hDB, 1, 0); slot(1, 0, 8'hDB, 0, 0); slot(1, 0, 8'hDB, 1, 1);
      // R5 WAIT with monitor clear: nothing
      cur_req = "R5"; slot(1, 1, 8'h9B, 0, 1);
      // R6 task switch, then R4 trap
      cur_req = "R6"; iv = 0; tsw = 1; cycle(); tsw = 0;
      cur_req = "R4"; slot(1, 0, 8'hDD, 1, 0);
      cur_req = "R5"; slot(1, 1, 8'h9B, 0, 1);
      // R7 write monitor+switched; slot in same cycle uses old flags
      cur_req = "R7";
      iv = 1; wt = 0; opc = 8'hDC; chk = 0; errn = 1; we = 1; wd = 32'h0000_0000; cycle();
      iv = 1; wt = 1; opc = 8'h9B; we = 1; wd = 32'h0000_000A; cycle(); we = 0;
      cur_req = "R5"; slot(1, 1, 8'h9B, 0, 1); slot(1, 1, 8'h00, 0, 1);
      // R3 emulate set, switched clear: escape traps, WAIT ignores emulate
      cur_req = "R7"; wr_cr0(32'h0000_0006, 0);
      cur_req = "R3"; slot(1, 0, 8'hDE, 1, 0); slot(1, 0, 8'hD8, 0, 1);
      cur_req = "R5"; slot(1, 1, 8'h9B, 0, 1);
      // R6 task switch wins over clearing write
      cur_req = "R6"; wr_cr0(32'h0000_0000, 1);
      cur_req = "R4"; slot(1, 0, 8'hD9, 0, 1);
      // R9 wide flag via write
      cur_req = "R9"; wr_cr0(32'h0000_0010, 0); wr_cr0(32'h0000_0000, 0);
      cur_req = "R1"; slot(1, 0, 8'hD9, 0, 1);
      // R8 reset with error line high -> narrow; then write wins over sample
      do_reset(1'b1, 1'b0, '0);
      cur_req = "R9"; slot(0, 0, 8'h00, 0, 1);
      do_reset(1'b0, 1'b1, 32'h0000_0000);
      cur_req = "R9"; slot(1, 0, 8'hDA, 0, 0);
      // R11 random mix
      cur_req = "R11";
      for (int i = 0; i < 3000; i++) begin
         iv   = ($urandom % 4) != 0;
         wt   = ($urandom % 5) == 0;
         opc  = ($urandom % 2) ? {5'b11011, 3'($urandom)} : 8'($urandom);
         chk  = $urandom % 2;
         errn = $urandom % 2;
         tsw  = ($urandom % 16) == 0;
         we   = ($urandom % 8) == 0;
         wd   = $urandom;
         cycle();
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         miscompares++;
         $display("FAIL R11: watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule